// File: doc/BRIEF.md
# Glitch-Tolerant Reset Guard

This block sits between an unfiltered active-low reset pin and the rest of a clock domain. It produces a system reset that changes only on clock edges, both when it asserts and when it releases, so that every internal register enters and leaves reset on the same edge. It also produces an output-enable for pads that face the outside world. That enable drops at once, without waiting for a clock, but only when a second, stricter reset input falls. The stricter input is a copy of the reset that has already passed an external pulse-width filter.

A short glitch on the raw pin never reaches internal state asynchronously. The main capture flop is cleared, the clear walks through the synchronizer, and the result is a synchronous reset pulse two clock edges later. The output-enable drops together with that pulse.

The block also holds a small bank of registers that reset does not clear. The write request for that bank is registered by logic that is reset synchronously, and the write is blocked while the system reset is low. A reset that arrives close to a clock edge can therefore stop a write, but it can never send that write to a different entry.

Top module: `reset_guard`

## Requirements
- R1: After `rst_raw_ni` falls, `sys_rst_no` stays high until a clock edge and is low after the second rising edge of `clk_i`. It never changes between edges.
- R2: After `rst_raw_ni` rises and stays high, `sys_rst_no` is still low after the second rising edge and goes high on the third rising edge.
- R3: While `rst_qual_ni` is low, `io_en_o` is low. It drops as soon as `rst_qual_ni` falls, before any clock edge.
- R4: A runt low pulse on `rst_raw_ni` that falls and rises between two edges, with `rst_qual_ni` held high, leaves `io_en_o` high until the second edge. After that edge both `io_en_o` and `sys_rst_no` are low for one cycle. `io_en_o` is never high while `sys_rst_no` is low.
- R5: If a runt on `rst_raw_ni` is followed, before the second edge, by a full pulse on both reset inputs, `io_en_o` drops as soon as the full pulse begins.
- R6: `io_en_o` returns high on the first rising edge after the edge that releases `sys_rst_no`, and only if `rst_qual_ni` is high. If `rst_qual_ni` stays low, `io_en_o` stays low.
- R7: Consider a write request (`wr_en_i`=1, 2-bit `wr_addr_i` selecting one of 4 entries, 8-bit `wr_data_i`) that is present at rising edge k while the system is out of reset. It appears on `rd_data_o` for `rd_addr_i` equal to that address after edge k+1. A request with `wr_en_i`=0 changes nothing. The read is combinational.
- R8: Reset never clears the register bank. A write request presented while `sys_rst_no` is low is dropped, and every entry keeps its value across reset.
- R9: A write that is already in flight when a reset pulse begins either lands at its own address or is dropped. No other entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain clock |
| rst_raw_ni | input | 1 | Unfiltered active-low reset pin |
| rst_qual_ni | input | 1 | Active-low reset that has passed a strict pulse-width filter |
| wr_en_i | input | 1 | Write request for the reset-exempt bank |
| wr_addr_i | input | 2 | Entry to write |
| wr_data_i | input | 8 | Data to write |
| rd_addr_i | input | 2 | Entry to read |
| rd_data_o | output | 8 | Contents of the selected entry |
| sys_rst_no | output | 1 | Synchronized active-low system reset |
| io_en_o | output | 1 | Enable for outward-facing outputs |

## Verification
The system reset is due two rising edges after the raw pin falls and three edges after it rises. The output-enable is due one edge after the system reset releases, and it drops with no clock at all on the strict input. A write is visible one edge after the edge that captures it. The bench drives every input 500 ps after a rising edge and samples one edge at a time, so each expected value is checked at the exact edge count it is due and also one edge earlier, when it must not yet have appeared. The asynchronous drops are sampled a fraction of a period after the stimulus, well before the next edge, so a clocked path cannot pass for them.

// File: rtl/reset_guard_pkg.sv
package reset_guard_pkg;
  parameter int unsigned RG_SYNC_STAGES = 2;
  parameter int unsigned RG_ADDR_W      = 2;
  parameter int unsigned RG_DATA_W      = 8;
endpackage

// File: rtl/rg_sys_sync.sv
module rg_sys_sync #(
  parameter int unsigned STAGES = reset_guard_pkg::RG_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_raw_ni,
  output logic sys_rst_no
);
  localparam int unsigned LAST = STAGES - 1;

  logic             cap_q;
  logic [LAST:0]    stg_q;

  // only this flop sees the raw pin asynchronously
  always_ff @(posedge clk_i or negedge rst_raw_ni) begin
    if (!rst_raw_ni) cap_q <= 1'b0;
    else             cap_q <= 1'b1;
  end

  always_ff @(posedge clk_i) stg_q[0] <= cap_q;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i) stg_q[g] <= stg_q[g-1];
  end

  assign sys_rst_no = stg_q[LAST];
endmodule

// File: rtl/rg_io_gate.sv
module rg_io_gate (
  input  logic clk_i,
  input  logic rst_qual_ni,
  input  logic sys_rst_ni,
  output logic io_en_o
);
  logic io_q;

  // strict path: immediate drop, re-arm one edge after system release
  always_ff @(posedge clk_i or negedge rst_qual_ni) begin
    if (!rst_qual_ni) io_q <= 1'b0;
    else              io_q <= sys_rst_ni;
  end

  assign io_en_o = io_q & sys_rst_ni;
endmodule

// File: rtl/rg_exempt_regs.sv
module rg_exempt_regs #(
  parameter int unsigned ADDR_W = reset_guard_pkg::RG_ADDR_W,
  parameter int unsigned DATA_W = reset_guard_pkg::RG_DATA_W
) (
  input  logic              clk_i,
  input  logic              sys_rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  wr_req_t                       req_q;
  logic [DEPTH-1:0][DATA_W-1:0]  bank;

  always_ff @(posedge clk_i) begin
    if (!sys_rst_ni) req_q.en <= 1'b0;
    else             req_q.en <= wr_en_i;
    req_q.addr <= wr_addr_i;
    req_q.data <= wr_data_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [DATA_W-1:0] entry_q;
    // no reset: contents survive, writes blocked while in reset
    always_ff @(posedge clk_i) begin
      if (req_q.en && sys_rst_ni && (req_q.addr == ADDR_W'(g)))
        entry_q <= req_q.data;
    end
    assign bank[g] = entry_q;
  end

  assign rd_data_o = bank[rd_addr_i];
endmodule

// File: rtl/reset_guard.sv
module reset_guard #(
  parameter int unsigned SYNC_STAGES = reset_guard_pkg::RG_SYNC_STAGES,
  parameter int unsigned ADDR_W      = reset_guard_pkg::RG_ADDR_W,
  parameter int unsigned DATA_W      = reset_guard_pkg::RG_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_raw_ni,
  input  logic              rst_qual_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sys_rst_no,
  output logic              io_en_o
);
  logic sys_rst_n;

  rg_sys_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_raw_ni (rst_raw_ni),
    .sys_rst_no (sys_rst_n)
  );

  rg_io_gate u_io (
    .clk_i       (clk_i),
    .rst_qual_ni (rst_qual_ni),
    .sys_rst_ni  (sys_rst_n),
    .io_en_o     (io_en_o)
  );

  rg_exempt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .sys_rst_ni (sys_rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  assign sys_rst_no = sys_rst_n;
endmodule

// File: rtl/reset_guard_sva.sv
module reset_guard_sva #(
  parameter int unsigned ADDR_W = reset_guard_pkg::RG_ADDR_W,
  parameter int unsigned DATA_W = reset_guard_pkg::RG_DATA_W
) (
  input logic              clk_i,
  input logic              rst_raw_ni,
  input logic              rst_qual_ni,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sys_rst_no,
  input logic              io_en_o
);
  // history guard: properties look back at most two cycles
  logic [1:0] age_q = 2'd0;
  logic       armed;
  always_ff @(posedge clk_i) if (age_q != 2'd3) age_q <= age_q + 2'd1;
  assign armed = (age_q == 2'd3);

  p_sys_assert_r1: assert property (@(posedge clk_i) disable iff (!armed)
    !rst_raw_ni |=> ##1 !sys_rst_no);

  p_sys_release_r2: assert property (@(posedge clk_i) disable iff (!armed)
    $rose(sys_rst_no) |-> ($past(rst_raw_ni) && $past(rst_raw_ni, 2)));

  p_io_qual_r3: assert property (@(posedge clk_i) disable iff (!armed)
    !rst_qual_ni |-> !io_en_o);

  p_io_needs_sys_r4: assert property (@(posedge clk_i) disable iff (!armed)
    io_en_o |-> sys_rst_no);

  p_io_rearm_r6: assert property (@(posedge clk_i) disable iff (!armed)
    $rose(io_en_o) |-> ($past(sys_rst_no) && rst_qual_ni));

  p_hold_in_reset_r8: assert property (@(posedge clk_i) disable iff (!armed)
    !sys_rst_no |=> ($stable(rd_addr_i) -> $stable(rd_data_o)));
endmodule

bind reset_guard reset_guard_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk_i       (clk_i),
  .rst_raw_ni  (rst_raw_ni),
  .rst_qual_ni (rst_qual_ni),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .sys_rst_no  (sys_rst_no),
  .io_en_o     (io_en_o)
);

// File: tb/reset_guard_test.sv
module reset_guard_test;
  // time unit 1 ps: 4000 ps period, 250 MHz
  localparam int HALF = 2000;

  logic       clk = 1'b0;
  logic       rst_raw_n = 1'b0, rst_qual_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sys_rst_n, io_en;

  int checks = 0, errors = 0;

  always #HALF clk = ~clk;

  reset_guard uut (
    .clk_i(clk), .rst_raw_ni(rst_raw_n), .rst_qual_ni(rst_qual_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sys_rst_no(sys_rst_n), .io_en_o(io_en)
  );

  // {en, addr[1:0], data[7:0], rd_addr[1:0], expected[7:0]}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 2'd0, 8'h11, 2'd0, 8'h11},
    {1'b1, 2'd1, 8'h22, 2'd1, 8'h22},
    {1'b1, 2'd2, 8'h33, 2'd2, 8'h33},
    {1'b1, 2'd3, 8'h44, 2'd3, 8'h44},
    {1'b0, 2'd3, 8'h99, 2'd3, 8'h44},
    {1'b1, 2'd3, 8'h55, 2'd0, 8'h11},
    {1'b1, 2'd0, 8'h66, 2'd3, 8'h55},
    {1'b0, 2'd1, 8'h77, 2'd1, 8'h22}
  };

  task automatic tick();
    @(posedge clk);
    #500;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    rd_addr = a;
    #10;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  // release both inputs and walk the release sequence (R2, R6)
  task automatic release_all();
    rst_raw_n = 1'b1;
    rst_qual_n = 1'b1;
    tick(); chk("R2 sys low edge1", 32'(sys_rst_n), 0);
    tick(); chk("R2 sys low edge2", 32'(sys_rst_n), 0);
    tick(); chk("R2 sys high edge3", 32'(sys_rst_n), 1);
    chk("R6 io still low edge3", 32'(io_en), 0);
    tick(); chk("R6 io high edge4", 32'(io_en), 1);
  endtask

  initial begin
    repeat (4) tick();
    chk("R1 reset state sys", 32'(sys_rst_n), 0);
    chk("R3 reset state io", 32'(io_en), 0);
    release_all();

    // R7 vector walk
    foreach (VEC[i]) begin
      wr_en   = VEC[i][20];
      wr_addr = VEC[i][19:18];
      wr_data = VEC[i][17:10];
      rd_addr = VEC[i][9:8];
      tick();
      wr_en = 1'b0;
      tick();
      chk($sformatf("R7 vector %0d", i), 32'(rd_data), 32'(VEC[i][7:0]));
    end

    // R7 latency: not visible after the capturing edge, visible one later
    rd_addr = 2'd2; wr_addr = 2'd2; wr_data = 8'hC3; wr_en = 1'b1;
    tick(); wr_en = 1'b0;
    chk("R7 not yet written", 32'(rd_data), 32'h33);
    tick();
    chk("R7 written next edge", 32'(rd_data), 32'hC3);
    wr_en = 1'b1; wr_data = 8'h33; tick(); wr_en = 1'b0; tick();

    // clean pulse: R3 async drop, R1 clocked assertion
    rst_raw_n = 1'b0; rst_qual_n = 1'b0;
    #250;
    chk("R3 io drops without clock", 32'(io_en), 0);
    chk("R1 sys waits for edge", 32'(sys_rst_n), 1);
    tick(); chk("R1 sys high edge1", 32'(sys_rst_n), 1);
    tick(); chk("R1 sys low edge2", 32'(sys_rst_n), 0);
    tick();
    release_all();
    rd_chk("R8 entry0 kept", 2'd0, 8'h66);
    rd_chk("R8 entry1 kept", 2'd1, 8'h22);
    rd_chk("R8 entry2 kept", 2'd2, 8'h33);
    rd_chk("R8 entry3 kept", 2'd3, 8'h55);

    // R8 write during reset is dropped
    rst_raw_n = 1'b0; rst_qual_n = 1'b0;
    repeat (3) tick();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'hAA;
    tick(); tick(); wr_en = 1'b0;
    release_all();
    rd_chk("R8 write in reset dropped", 2'd1, 8'h22);

    // R9 write in flight when reset begins
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hEE;
    rst_raw_n = 1'b0; rst_qual_n = 1'b0;
    tick(); wr_en = 1'b0;
    repeat (3) tick();
    release_all();
    rd_chk("R9 in-flight lands at own entry", 2'd3, 8'hEE);
    rd_chk("R9 neighbour untouched", 2'd2, 8'h33);
    rd_chk("R9 entry0 untouched", 2'd0, 8'h66);

    // R6 strict input held low keeps outputs off
    rst_raw_n = 1'b0; rst_qual_n = 1'b0;
    repeat (3) tick();
    rst_raw_n = 1'b1;
    repeat (5) tick();
    chk("R6 sys released", 32'(sys_rst_n), 1);
    chk("R6 io held by strict input", 32'(io_en), 0);
    rst_qual_n = 1'b1;
    tick(); chk("R6 io re-arms one edge later", 32'(io_en), 1);

    // R4 runt on raw pin only
    rst_raw_n = 1'b0; #500; rst_raw_n = 1'b1;
    chk("R4 runt no async drop", 32'(io_en), 1);
    tick(); chk("R4 io high edge1", 32'(io_en), 1);
    chk("R4 sys high edge1", 32'(sys_rst_n), 1);
    tick(); chk("R4 sys low edge2", 32'(sys_rst_n), 0);
    chk("R4 io low edge2", 32'(io_en), 0);
    tick(); chk("R4 sys back edge3", 32'(sys_rst_n), 1);
    chk("R4 io low edge3", 32'(io_en), 0);
    tick(); chk("R4 io back edge4", 32'(io_en), 1);
    rd_chk("R8 runt keeps entry3", 2'd3, 8'hEE);

    // R5 runt then full pulse before the delayed reset arrives
    rst_raw_n = 1'b0; #500; rst_raw_n = 1'b1; #250;
    rst_raw_n = 1'b0; rst_qual_n = 1'b0; #250;
    chk("R5 full pulse drops io at once", 32'(io_en), 0);
    repeat (3) tick();
    chk("R5 sys low", 32'(sys_rst_n), 0);
    release_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(longint'(200000) * 4000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule